// File: doc/BRIEF.md
# Pixel Word Serializing Transmitter

This block takes one parallel pixel word per pixel strobe and sends it out bit-serially on one, two or three data lanes. A word carries three 8-bit colour channels, horizontal sync, vertical sync, a data-valid bit, a 2-bit side channel and a parity bit that the block computes. Together they form a 30-bit serial word. A 2-bit lane selector picks how many lanes carry that word, and so how many bit slots a pixel needs.

The whole block runs on one fast clock. The bit rate comes from an internal clock enable that divides the fast clock by a parameter; it stands in for a bit-clock multiplier. Every pixel strobe sets the phase of the bit timing. A pixel-rate clock marker is driven next to the lanes, and its rising edge marks slot 0 of each pixel. An active-low halt input holds every output at zero and ignores strobes. This gives a purely digital model of a serial display-link transmitter.

Top module: `pxs_serializer_tx`

## Requirements
- R1: The serial word is 30 bits, bit k sent in order of k: bit 0 parity, bits 2:1 side channel (aux[0] at bit 1), bit 3 data-valid, bit 4 vertical sync, bit 5 horizontal sync, bits 13:6 blue, bits 21:14 green, bits 29:22 red, each field with its LSB at the lowest position.
- R2: The parity bit makes the count of ones over the 24 colour bits, the two sync bits, the data-valid bit and the parity bit even. The side-channel bits do not affect it.
- R3: The lane selector encodes 00 as one lane (30 slots), 01 as two lanes (15 slots) and 10 or 11 as three lanes (10 slots). With N lanes, word bit k is driven on lane_o[k mod N] in slot k div N, and lanes at or above N are driven 0.
- R4: The colour, sync, data-valid, side-channel and lane-selector inputs are captured only in a cycle where pix_stb is high. Changes to them while a word is being sent have no effect on that word.
- R5: Slot 0 appears on the outputs in the cycle after the strobe cycle. Each slot lasts CYC_PER_BIT cycles, and bit_stb_o pulses in the first cycle of every slot, so it pulses exactly 30/N times for a word that runs to completion.
- R6: pclk_o rises together with slot 0 of every word. It stays high for the first floor(S/2) slots of an S-slot word and is low for the rest.
- R7: When the last slot has run out and no new strobe has come, lane_o, bit_stb_o and pclk_o return to 0 and stay there.
- R8: A strobe that arrives while a word is still being sent drops the rest of that word and starts the new word at slot 0.
- R9: While halt_n is low, from the next cycle on all outputs are 0 and strobes are ignored. After halt_n is released the block stays idle until the next strobe.
- R10: During and after synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_n | input | 1 | Active-low halt; low forces all outputs idle |
| pix_stb | input | 1 | Pixel strobe; captures the parallel word and starts it |
| lane_sel | input | 2 | Lane count selector (00 one, 01 two, 10/11 three) |
| px_red | input | 8 | Red colour channel |
| px_green | input | 8 | Green colour channel |
| px_blue | input | 8 | Blue colour channel |
| px_hsync | input | 1 | Horizontal sync |
| px_vsync | input | 1 | Vertical sync |
| px_den | input | 1 | Data-valid flag |
| px_aux | input | 2 | Side-channel bits, excluded from parity |
| lane_o | output | 3 | Serial data lanes |
| bit_stb_o | output | 1 | Pulses in the first cycle of each bit slot |
| pclk_o | output | 1 | Forwarded pixel-rate clock marker |

## Verification
The bench builds the block with CYC_PER_BIT set to 2, so every slot spans two cycles. This brings the divider's hold cycle into reach: the lanes must stay stable and bit_stb_o must stay low inside a slot. The colour and side-channel widths stay at 8 and 2, so the word keeps its 30-bit layout and all lane codes, including the duplicate three-lane code, give whole slot counts. Strobes arrive back-to-back, after idle gaps, partway through a word and during halt, which reaches the restart, idle-return and halt paths.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  localparam int NUM_LANES = 3;

  typedef logic [1:0] lane_cnt_t;

  // lane selector to lane count; the spare code maps to three lanes
  function automatic lane_cnt_t lanes_of(input logic [1:0] sel);
    case (sel)
      2'b00:   lanes_of = 2'd1;
      2'b01:   lanes_of = 2'd2;
      default: lanes_of = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/pxs_word_pack.sv
module pxs_word_pack #(
  parameter int COLOR_W = 8,
  parameter int AUX_W   = 2,
  localparam int WORD_W = 3 * COLOR_W + 3 + AUX_W + 1
) (
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               den,
  input  logic [AUX_W-1:0]   aux,
  output logic [WORD_W-1:0]  word
);

  logic par;

  // even parity over colour and control bits; side channel left out
  assign par  = ^{red, green, blue, hsync, vsync, den};
  assign word = {red, green, blue, hsync, vsync, den, aux, par};

endmodule

// File: rtl/pxs_lane_mux.sv
module pxs_lane_mux #(
  parameter int WORD_W = 30,
  parameter int LANES  = 3,
  localparam int SLOT_W = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        cnt,
  input  logic [SLOT_W-1:0] slot,
  output logic [LANES-1:0]  lanes
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] sh;
    assign sh       = word >> (int'(slot) * int'(cnt) + l);
    assign lanes[l] = (l < int'(cnt)) ? sh[0] : 1'b0;
  end

endmodule

// File: rtl/pxs_bit_timer.sv
module pxs_bit_timer #(
  parameter int WORD_W      = 30,
  parameter int CYC_PER_BIT = 1,
  localparam int SLOT_W = $clog2(WORD_W + 1),
  localparam int DIV_W  = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_n,
  input  logic              load,
  input  logic [SLOT_W-1:0] slots,
  output logic              act_n,
  output logic [SLOT_W-1:0] slot_n,
  output logic              step
);

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_PER_BIT - 1);

  logic              act_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DIV_W-1:0]  div_q, div_n;

  always_comb begin
    act_n  = act_q;
    slot_n = slot_q;
    div_n  = div_q;
    step   = 1'b0;
    if (load) begin
      act_n  = 1'b1;
      slot_n = '0;
      div_n  = '0;
      step   = 1'b1;
    end else if (act_q) begin
      if (div_q == DIV_LAST) begin
        div_n = '0;
        if (slot_q == slots - SLOT_W'(1)) begin
          act_n  = 1'b0;
          slot_n = '0;
        end else begin
          slot_n = slot_q + SLOT_W'(1);
          step   = 1'b1;
        end
      end else begin
        div_n = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !halt_n) begin
      act_q  <= 1'b0;
      slot_q <= '0;
      div_q  <= '0;
    end else begin
      act_q  <= act_n;
      slot_q <= slot_n;
      div_q  <= div_n;
    end
  end

endmodule

// File: rtl/pxs_serializer_tx.sv
module pxs_serializer_tx
  import pxs_pkg::*;
#(
  parameter int COLOR_W     = 8,
  parameter int AUX_W       = 2,
  parameter int CYC_PER_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_n,
  input  logic               pix_stb,
  input  logic [1:0]         lane_sel,
  input  logic [COLOR_W-1:0] px_red,
  input  logic [COLOR_W-1:0] px_green,
  input  logic [COLOR_W-1:0] px_blue,
  input  logic               px_hsync,
  input  logic               px_vsync,
  input  logic               px_den,
  input  logic [AUX_W-1:0]   px_aux,
  output logic [2:0]         lane_o,
  output logic               bit_stb_o,
  output logic               pclk_o
);

  localparam int WORD_W = 3 * COLOR_W + 3 + AUX_W + 1;
  localparam int SLOT_W = $clog2(WORD_W + 1);

  function automatic logic [SLOT_W-1:0] slots_of(input lane_cnt_t n);
    case (n)
      2'd1:    slots_of = SLOT_W'(WORD_W);
      2'd2:    slots_of = SLOT_W'((WORD_W + 1) / 2);
      default: slots_of = SLOT_W'((WORD_W + 2) / 3);
    endcase
  endfunction

  logic                  load;
  logic [WORD_W-1:0]     word_in, word_q, word_n;
  lane_cnt_t             cnt_in, cnt_q, cnt_n;
  logic [SLOT_W-1:0]     slots_n, slot_n;
  logic                  act_n, step;
  logic [NUM_LANES-1:0]  lanes_n;

  assign load    = pix_stb && halt_n;
  assign cnt_in  = lanes_of(lane_sel);
  assign word_n  = load ? word_in : word_q;
  assign cnt_n   = load ? cnt_in : cnt_q;
  assign slots_n = slots_of(cnt_n);

  pxs_word_pack #(
    .COLOR_W (COLOR_W),
    .AUX_W   (AUX_W)
  ) u_pack (
    .red   (px_red),
    .green (px_green),
    .blue  (px_blue),
    .hsync (px_hsync),
    .vsync (px_vsync),
    .den   (px_den),
    .aux   (px_aux),
    .word  (word_in)
  );

  pxs_bit_timer #(
    .WORD_W      (WORD_W),
    .CYC_PER_BIT (CYC_PER_BIT)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .halt_n (halt_n),
    .load   (load),
    .slots  (slots_n),
    .act_n  (act_n),
    .slot_n (slot_n),
    .step   (step)
  );

  pxs_lane_mux #(
    .WORD_W (WORD_W),
    .LANES  (NUM_LANES)
  ) u_mux (
    .word  (word_n),
    .cnt   (cnt_n),
    .slot  (slot_n),
    .lanes (lanes_n)
  );

  always_ff @(posedge clk) begin
    if (rst || !halt_n) begin
      word_q    <= '0;
      cnt_q     <= 2'd1;
      lane_o    <= '0;
      bit_stb_o <= 1'b0;
      pclk_o    <= 1'b0;
    end else begin
      if (load) begin
        word_q <= word_in;
        cnt_q  <= cnt_in;
      end
      lane_o    <= act_n ? lanes_n : '0;
      bit_stb_o <= step;
      pclk_o    <= act_n && (slot_n < (slots_n >> 1));
    end
  end

endmodule

// File: rtl/pxs_serializer_tx_chk.sv
module pxs_serializer_tx_chk #(
  parameter int COLOR_W = 8,
  parameter int AUX_W   = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       halt_n,
  input logic       pix_stb,
  input logic [1:0] lane_sel,
  input logic [2:0] lane_o,
  input logic       bit_stb_o,
  input logic       pclk_o
);

  localparam int WORD_W = 3 * COLOR_W + 3 + AUX_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  logic [1:0]       sel_seen;
  logic [CNT_W-1:0] stb_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_seen <= 2'b00;
      stb_cnt  <= '0;
    end else if (pix_stb && halt_n) begin
      sel_seen <= lane_sel;
      stb_cnt  <= '0;
    end else if (bit_stb_o) begin
      stb_cnt  <= stb_cnt + CNT_W'(1);
    end
  end

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !halt_n |=> (lane_o == 3'b000 && !bit_stb_o && !pclk_o));

  // R6
  pclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk_o) |-> $past(pix_stb && halt_n));

  // R5
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_stb && halt_n) |=> (bit_stb_o && pclk_o));

  // R5
  stb_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |-> (stb_cnt < CNT_W'(WORD_W)));

  // R3
  one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_seen == 2'b00) |-> (lane_o[2:1] == 2'b00));

  // R3
  two_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_seen == 2'b01) |-> !lane_o[2]);

endmodule

bind pxs_serializer_tx pxs_serializer_tx_chk #(
  .COLOR_W (COLOR_W),
  .AUX_W   (AUX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halt_n    (halt_n),
  .pix_stb   (pix_stb),
  .lane_sel  (lane_sel),
  .lane_o    (lane_o),
  .bit_stb_o (bit_stb_o),
  .pclk_o    (pclk_o)
);

// File: tb/pxs_serializer_tx_test.sv
module pxs_serializer_tx_test;

  localparam int BD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_n = 1'b1;
  logic       pix_stb = 1'b0;
  logic [1:0] lane_sel = 2'b00;
  logic [7:0] px_red = '0, px_green = '0, px_blue = '0;
  logic       px_hsync = 1'b0, px_vsync = 1'b0, px_den = 1'b0;
  logic [1:0] px_aux = '0;
  logic [2:0] lane_o;
  logic       bit_stb_o, pclk_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pxs_serializer_tx #(
    .COLOR_W (8),
    .AUX_W   (2),
    .CYC_PER_BIT (BD)
  ) uut (
    .clk (clk), .rst (rst), .halt_n (halt_n), .pix_stb (pix_stb),
    .lane_sel (lane_sel), .px_red (px_red), .px_green (px_green),
    .px_blue (px_blue), .px_hsync (px_hsync), .px_vsync (px_vsync),
    .px_den (px_den), .px_aux (px_aux), .lane_o (lane_o),
    .bit_stb_o (bit_stb_o), .pclk_o (pclk_o)
  );

  function automatic logic [29:0] pack_word(input logic [7:0] r, g, b,
      input logic hs, vs, dv, input logic [1:0] ax);
    logic p;
    p = ^{r, g, b, hs, vs, dv};
    return {r, g, b, hs, vs, dv, ax, p};
  endfunction

  function automatic int lanes_for(input logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 3;
  endfunction

  function automatic logic [2:0] exp_lanes(input logic [29:0] w, input int n, input int slot);
    logic [2:0] e;
    e = '0;
    for (int l = 0; l < 3; l++) begin
      logic [29:0] sh;
      sh = w >> (slot * n + l);
      if (l < n) e[l] = sh[0];
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " lanes"}, 32'(lane_o), 32'd0);
    chk({tag, " strobe"}, 32'(bit_stb_o), 32'd0);
    chk({tag, " pclk"}, 32'(pclk_o), 32'd0);
  endtask

  // Called at a falling edge; ends at a falling edge.
  // cut > 0 stops after that many cycles (next strobe restarts, R8).
  task automatic run_pixel(input logic [7:0] r, g, b, input logic hs, vs, dv,
      input logic [1:0] ax, input logic [1:0] sel, input int gap,
      input bit scramble, input int cut);
    logic [29:0] w;
    int n, s, total, nstb;
    w = pack_word(r, g, b, hs, vs, dv, ax);
    n = lanes_for(sel);
    s = 30 / n;
    total = (cut > 0) ? cut : s * BD + gap;
    nstb = 0;
    px_red = r; px_green = g; px_blue = b;
    px_hsync = hs; px_vsync = vs; px_den = dv; px_aux = ax;
    lane_sel = sel;
    pix_stb = 1'b1;
    for (int c = 0; c < total; c++) begin
      @(negedge clk);
      if (c == 0) begin
        pix_stb = 1'b0;
        // R2: slot 0 of lane 0 carries the parity bit in every mode
        chk("R2 parity bit", 32'(lane_o[0]), 32'(w[0]));
        if (scramble) begin
          px_red = 8'($urandom); px_green = 8'($urandom); px_blue = 8'($urandom);
          px_aux = 2'($urandom); px_den = 1'($urandom);
          lane_sel = 2'($urandom);
        end
      end
      if (c < s * BD) begin
        // R1 R3 R4: lane contents follow the captured word
        chk("R3 lane data", 32'(lane_o), 32'(exp_lanes(w, n, c / BD)));
        chk("R5 bit strobe", 32'(bit_stb_o), 32'((c % BD) == 0));
        chk("R6 pixel clock", 32'(pclk_o), 32'((c / BD) < (s / 2)));
      end else begin
        idle_chk("R7 idle after word");
      end
      nstb += 32'(bit_stb_o);
    end
    if (cut == 0) chk("R5 strobes per pixel", 32'(nstb), 32'(s));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    idle_chk("R10 during reset");
    rst = 1'b0;
    @(negedge clk);
    idle_chk("R10 after reset");

    // directed words, every lane code
    run_pixel(8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 1'b1, 2'b10, 2'b00, 0, 1'b0, 0);
    run_pixel(8'hFF, 8'h00, 8'h81, 1'b0, 1'b1, 1'b1, 2'b01, 2'b01, 0, 1'b0, 0);
    run_pixel(8'h12, 8'h34, 8'h56, 1'b1, 1'b1, 1'b0, 2'b11, 2'b10, 0, 1'b0, 0);
    // R3: spare code behaves as three lanes
    run_pixel(8'h12, 8'h34, 8'h56, 1'b1, 1'b1, 1'b0, 2'b11, 2'b11, 3, 1'b0, 0);
    // R2: only the side channel differs; parity bit unchanged
    run_pixel(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, 0, 1'b0, 0);
    run_pixel(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b11, 2'b10, 2, 1'b0, 0);

    // R8: strobe partway through a word restarts at slot 0
    run_pixel(8'hC3, 8'h5A, 8'h99, 1'b0, 1'b1, 1'b0, 2'b01, 2'b00, 0, 1'b0, 7);
    run_pixel(8'h0E, 8'hE0, 8'h77, 1'b1, 1'b0, 1'b1, 2'b10, 2'b01, 0, 1'b1, 0);

    // R9: halt mid-word, strobes ignored while halted
    run_pixel(8'h55, 8'hAA, 8'h33, 1'b1, 1'b1, 1'b1, 2'b01, 2'b10, 0, 1'b0, 5);
    halt_n = 1'b0;
    pix_stb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pix_stb = (i % 2) == 0;
      idle_chk("R9 halted");
    end
    halt_n = 1'b1;
    pix_stb = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle_chk("R9 released, no strobe");
    end

    // random words, modes and gaps with inputs scrambled mid-word (R4)
    for (int k = 0; k < 40; k++) begin
      run_pixel(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                int'($urandom_range(0, 3)), 1'b1, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule